// File: doc/BRIEF.md
# Supply Brown-Out Event and Reset-Hold Controller

This block is the digital half of a supply monitor. An analog comparator reports whether the supply sits above an early-warning threshold. Its level comes in unsynchronised. The block resynchronises it and turns its crossings into interrupt events, with the active edge chosen by software. A falling crossing gives warning of imminent power loss, so software can park the system in a safe state. A rising crossing wakes the processor from stop mode.

The voltage event shares one non-maskable interrupt line with two other event sources: the watchdog expiry pulse and the oscillator-stop pulse. Each source has a sticky flag in a status register, and a write of 1 to a flag clears it. Software reads the status register to tell which source fired.

Independently of the interrupt path, a reset-hold output keeps the processor in reset while the supply is low. It releases only after the supply has stayed good for a programmable number of clock cycles.

Top module: `supply_guard`

## Requirements
- R1: After reset, `nmi_o` is 0 and `rst_hold_o` is 1. The control register (address 0) and the status register (address 1) read 0. The hold-count register (address 2) reads the parameter `HOLD_RST` (16 by default).
- R2: Control bit 0 arms the falling crossing. When it is 1, a 1-to-0 change of `vmon_i` sets status bit 0, and the flag is visible on the third rising clock edge after the change, because of the two-flop synchroniser. When control bit 0 is 0, a falling crossing leaves status bit 0 unchanged.
- R3: Control bit 1 arms the rising crossing in the same way. A 0-to-1 change of `vmon_i` sets status bit 0 only when control bit 1 is 1.
- R4: A one-cycle pulse on `wdg_expire_i` sets status bit 1 on the next edge, and a pulse on `osc_stop_i` sets status bit 2 on the next edge. These flags are recorded whatever the enables are. A flag stays set until it is cleared.
- R5: Writing address 1 clears each status bit whose written data bit is 1 and leaves the others. A source event in the same cycle as its clear wins, and the bit stays 1.
- R6: `nmi_o` is 1 exactly when some status bit k (k = 0, 1, 2) is set and control bit k+2 is 1. A flag whose enable is 0 raises no NMI.
- R7: `rst_hold_o` returns to 1 on the third rising edge after `vmon_i` goes low, even for a one-cycle dip. The hold counter restarts at that point.
- R8: `rst_hold_o` falls after the synchronised level has been high for N consecutive cycles, where N is the hold-count register, or 1 when that register is 0. In practice it falls N+2 edges after `vmon_i` rises.
- R9: Reading address 3 returns the synchronised comparator level in bit 0 and the reset hold in bit 1. All other read bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| vmon_i | input | 1 | Asynchronous comparator level, 1 = supply above warning threshold |
| wdg_expire_i | input | 1 | Watchdog expiry pulse |
| osc_stop_i | input | 1 | Oscillator-stop pulse |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 2 | Register address |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data, combinational from address |
| nmi_o | output | 1 | Shared non-maskable interrupt line |
| rst_hold_o | output | 1 | Reset request to the processor |

## Verification
Corruption in the synchroniser or the edge-history flop shows up as a status flag that appears one edge early or late, or appears for the disarmed polarity. Such a fault is visible on the status read and on `nmi_o` within three cycles of the comparator change.

A wrong hold counter moves the falling edge of `rst_hold_o` relative to the N+2 edge rule, or misses the reassertion after a dip. A stuck status bit outlives its write-1 clear by one cycle, and this shows at the status read and at `nmi_o` the cycle after the write.

// File: rtl/sg_pkg.sv
package sg_pkg;
    localparam int NSRC   = 3;
    localparam int SRC_V  = 0;
    localparam int SRC_WD = 1;
    localparam int SRC_OS = 2;

    localparam int CTRL_W   = 2 + NSRC;
    localparam int C_FALL   = 0;
    localparam int C_RISE   = 1;
    localparam int C_EN_LSB = 2;

    typedef enum logic [1:0] {
        A_CTRL  = 2'd0,
        A_STAT  = 2'd1,
        A_HOLD  = 2'd2,
        A_LEVEL = 2'd3
    } reg_addr_e;
endpackage

// File: rtl/sg_sync.sv
module sg_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        logic src_d;
        if (s == 0) begin : g_first
            assign src_d = d_i;
        end else begin : g_next
            assign src_d = chain_q[s-1];
        end
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) chain_q[s] <= 1'b0;
            else         chain_q[s] <= src_d;
        end
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/sg_level_track.sv
module sg_level_track #(
    parameter int CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             lvl_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic             rise_o,
    output logic             fall_o,
    output logic             hold_o
);
    typedef struct packed {
        logic             prev;
        logic [CNT_W-1:0] cnt;
        logic             hold;
    } trk_t;

    trk_t       trk_d, trk_q;
    logic [CNT_W:0] eff_lim, cnt_inc;

    always_comb begin
        trk_d      = trk_q;
        trk_d.prev = lvl_i;
        eff_lim    = (limit_i == '0) ? {{CNT_W{1'b0}}, 1'b1} : {1'b0, limit_i};
        cnt_inc    = {1'b0, trk_q.cnt} + {{CNT_W{1'b0}}, 1'b1};
        if (!lvl_i) begin
            trk_d.cnt  = '0;
            trk_d.hold = 1'b1;
        end else if (trk_q.hold) begin
            trk_d.cnt = cnt_inc[CNT_W-1:0];
            if (cnt_inc >= eff_lim) trk_d.hold = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) trk_q <= '{prev: 1'b0, cnt: '0, hold: 1'b1};
        else         trk_q <= trk_d;
    end

    assign rise_o = lvl_i & ~trk_q.prev;
    assign fall_o = ~lvl_i & trk_q.prev;
    assign hold_o = trk_q.hold;

    // R7: a low synchronised level forces the hold on the next edge
    p_hold_on_low_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !lvl_i |=> hold_o);
    // R8: release only ever follows a good level
    p_release_good_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(hold_o) |-> $past(lvl_i));
    // R8: while held and the level stays high, the counter advances
    p_count_adv_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (hold_o && lvl_i && $past(hold_o) && $past(lvl_i)) |-> (trk_q.cnt != '0));
endmodule

// File: rtl/sg_regs.sv
module sg_regs
    import sg_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int CNT_W    = 16,
    parameter int HOLD_RST = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_i,
    input  logic [1:0]        addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [NSRC-1:0]   set_i,
    input  logic              lvl_i,
    input  logic              hold_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic [CNT_W-1:0]  limit_o,
    output logic              fall_en_o,
    output logic              rise_en_o,
    output logic              nmi_o
);
    typedef struct packed {
        logic [CTRL_W-1:0] ctrl;
        logic [NSRC-1:0]   stat;
        logic [CNT_W-1:0]  limit;
    } regs_t;

    regs_t           regs_d, regs_q;
    logic [NSRC-1:0] clr;
    reg_addr_e       addr;

    assign addr = reg_addr_e'(addr_i);

    always_comb begin
        regs_d = regs_q;
        clr    = '0;
        if (wr_i) begin
            unique case (addr)
                A_CTRL:  regs_d.ctrl  = wdata_i[CTRL_W-1:0];
                A_STAT:  clr          = wdata_i[NSRC-1:0];
                A_HOLD:  regs_d.limit = wdata_i[CNT_W-1:0];
                default: ;
            endcase
        end
        regs_d.stat = (regs_q.stat & ~clr) | set_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) regs_q <= '{ctrl: '0, stat: '0, limit: CNT_W'(HOLD_RST)};
        else         regs_q <= regs_d;
    end

    always_comb begin
        unique case (addr)
            A_CTRL:  rdata_o = DATA_W'(regs_q.ctrl);
            A_STAT:  rdata_o = DATA_W'(regs_q.stat);
            A_HOLD:  rdata_o = DATA_W'(regs_q.limit);
            default: rdata_o = DATA_W'({hold_i, lvl_i});
        endcase
    end

    assign limit_o   = regs_q.limit;
    assign fall_en_o = regs_q.ctrl[C_FALL];
    assign rise_en_o = regs_q.ctrl[C_RISE];
    assign nmi_o     = |(regs_q.stat & regs_q.ctrl[C_EN_LSB +: NSRC]);

    for (genvar k = 0; k < NSRC; k++) begin : g_flag_chk
        // R4: a raised flag persists unless cleared
        p_sticky_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (regs_q.stat[k] && !clr[k]) |=> regs_q.stat[k]);
        // R5: clear without a competing event drops the flag
        p_w1c_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (clr[k] && !set_i[k]) |=> !regs_q.stat[k]);
        // R5: an event always lands, even against a clear
        p_set_wins_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
            set_i[k] |=> regs_q.stat[k]);
    end
endmodule

// File: rtl/supply_guard.sv
module supply_guard
    import sg_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int CNT_W       = 16,
    parameter int DATA_W      = 16,
    parameter int HOLD_RST    = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              vmon_i,
    input  logic              wdg_expire_i,
    input  logic              osc_stop_i,
    input  logic              bus_wr_i,
    input  logic [1:0]        bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              nmi_o,
    output logic              rst_hold_o
);
    logic             lvl_s, rise_ev, fall_ev, fall_en, rise_en;
    logic [CNT_W-1:0] limit;
    logic [NSRC-1:0]  src_set;

    sg_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .d_i   (vmon_i),
        .q_o   (lvl_s)
    );

    sg_level_track #(.CNT_W(CNT_W)) u_track (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .lvl_i  (lvl_s),
        .limit_i(limit),
        .rise_o (rise_ev),
        .fall_o (fall_ev),
        .hold_o (rst_hold_o)
    );

    always_comb begin
        src_set         = '0;
        src_set[SRC_V]  = (rise_ev & rise_en) | (fall_ev & fall_en);
        src_set[SRC_WD] = wdg_expire_i;
        src_set[SRC_OS] = osc_stop_i;
    end

    sg_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W), .HOLD_RST(HOLD_RST)) u_regs (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .wr_i     (bus_wr_i),
        .addr_i   (bus_addr_i),
        .wdata_i  (bus_wdata_i),
        .set_i    (src_set),
        .lvl_i    (lvl_s),
        .hold_i   (rst_hold_o),
        .rdata_o  (bus_rdata_o),
        .limit_o  (limit),
        .fall_en_o(fall_en),
        .rise_en_o(rise_en),
        .nmi_o    (nmi_o)
    );

    // R2: the two crossings are never reported together
    p_edge_excl_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(rise_ev && fall_ev));
    // R6: a watchdog pulse raises the line on the next edge when its enable stays set
    p_wdg_nmi_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wdg_expire_i && u_regs.regs_q.ctrl[C_EN_LSB + SRC_WD] && !bus_wr_i) |=> nmi_o);
endmodule

// File: tb/supply_guard_tb.sv
`timescale 1ns/1ps
module supply_guard_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        vmon = 1'b0, wdg = 1'b0, osc = 1'b0, bwr = 1'b0;
    logic [1:0]  baddr = 2'd0;
    logic [15:0] bwdata = '0;
    logic [15:0] brdata;
    logic        nmi, hold;
    int          n_checks = 0, n_err = 0;

    // model state for the random phase
    logic        m_s1, m_s2, m_prev, m_hold;
    logic [2:0]  m_stat;
    logic [4:0]  m_ctrl;
    logic [15:0] m_lim, m_cnt;

    always #2.5 clk = ~clk;

    supply_guard u_dut (
        .clk_i(clk), .rst_ni(rst_n), .vmon_i(vmon), .wdg_expire_i(wdg),
        .osc_stop_i(osc), .bus_wr_i(bwr), .bus_addr_i(baddr),
        .bus_wdata_i(bwdata), .bus_rdata_o(brdata), .nmi_o(nmi), .rst_hold_o(hold)
    );

    task automatic tick(input int n);
        repeat (n) begin @(posedge clk); @(negedge clk); end
    endtask

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        baddr = a; bwdata = d; bwr = 1'b1;
        tick(1);
        bwr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        baddr = a; #1; d = brdata;
    endtask

    function automatic logic m_nmi_f(input logic [2:0] st, input logic [4:0] c);
        return |(st & c[4:2]);
    endfunction

    task automatic model_step(input logic c, input logic w, input logic o,
                              input logic we, input logic [1:0] a, input logic [15:0] d);
        logic [2:0]  set, clr;
        logic [15:0] eff;
        set    = {o, w, ((m_s2 & ~m_prev) & m_ctrl[1]) | ((~m_s2 & m_prev) & m_ctrl[0])};
        clr    = (we && a == 2'd1) ? d[2:0] : 3'b000;
        eff    = (m_lim == 0) ? 16'd1 : m_lim;
        if (!m_s2) begin m_cnt = 0; m_hold = 1'b1; end
        else if (m_hold) begin
            if (m_cnt + 16'd1 >= eff) m_hold = 1'b0;
            m_cnt = m_cnt + 16'd1;
        end
        m_stat = (m_stat & ~clr) | set;
        if (we && a == 2'd0) m_ctrl = d[4:0];
        if (we && a == 2'd2) m_lim = d;
        m_prev = m_s2; m_s2 = m_s1; m_s1 = c;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_err++; n_checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

    initial begin : main
        logic [15:0] r;
        void'($urandom(32'h00c0ffee));
        tick(2);
        rst_n = 1'b1;
        tick(1);
        // R1 reset state
        chk("R1", "nmi", nmi, 0);
        chk("R1", "hold", hold, 1);
        rd(2'd0, r); chk("R1", "ctrl", r, 0);
        rd(2'd1, r); chk("R1", "status", r, 0);
        rd(2'd2, r); chk("R1", "limit", r, 16);

        // R8 release timing with limit 5
        wr(2'd2, 16'd5);
        vmon = 1'b1;
        tick(6); chk("R8", "hold before N+2", hold, 1);
        tick(1); chk("R8", "hold at N+2", hold, 0);
        rd(2'd3, r); chk("R9", "level readback", r, 16'h0001);
        rd(2'd1, r); chk("R3", "rise disarmed no flag", r, 0);

        // R2 falling crossing armed, volt NMI enabled
        wr(2'd0, 16'h0005);
        vmon = 1'b0;
        tick(2); chk("R2", "nmi before sync", nmi, 0);
        tick(1); chk("R2", "nmi after fall", nmi, 1);
        chk("R7", "hold on low", hold, 1);
        rd(2'd1, r); chk("R2", "status volt", r, 16'h0001);
        rd(2'd3, r); chk("R9", "level low held", r, 16'h0002);
        // R5 clear
        wr(2'd1, 16'h0001);
        chk("R5", "nmi after clear", nmi, 0);
        rd(2'd1, r); chk("R5", "status cleared", r, 0);

        // R3 rise disarmed, then armed
        wr(2'd0, 16'h0004);
        vmon = 1'b1; tick(4);
        rd(2'd1, r); chk("R3", "rise disarmed", r, 0);
        vmon = 1'b0; tick(4);
        rd(2'd1, r); chk("R2", "fall disarmed", r, 0);
        wr(2'd0, 16'h0006);
        vmon = 1'b1; tick(2);
        chk("R3", "nmi before sync", nmi, 0);
        tick(1); chk("R3", "nmi after rise", nmi, 1);
        wr(2'd1, 16'h0007);

        // R4/R6 watchdog flag with enable off
        wdg = 1'b1; tick(1); wdg = 1'b0;
        rd(2'd1, r); chk("R4", "wdg flag", r, 16'h0002);
        chk("R6", "masked no nmi", nmi, 0);
        tick(3); rd(2'd1, r); chk("R4", "wdg sticky", r, 16'h0002);
        wr(2'd0, 16'h000e);
        chk("R6", "unmasked nmi", nmi, 1);
        // R5 set wins over clear
        osc = 1'b1; wr(2'd1, 16'h0004); osc = 1'b0;
        rd(2'd1, r); chk("R5", "set beats clear", r, 16'h0006);
        wr(2'd1, 16'h0002);
        rd(2'd1, r); chk("R5", "partial clear", r, 16'h0004);

        // R7 one-cycle dip restarts the hold
        tick(10);
        chk("R8", "released", hold, 0);
        vmon = 1'b0; tick(1); vmon = 1'b1;
        tick(2); chk("R7", "dip reasserts", hold, 1);
        tick(4); chk("R7", "still held", hold, 1);
        tick(1); chk("R7", "re-released", hold, 0);

        // random phase against a cycle model
        rst_n = 1'b0; vmon = 1'b0; tick(2); rst_n = 1'b1;
        m_s1 = 0; m_s2 = 0; m_prev = 0; m_hold = 1; m_stat = 0;
        m_ctrl = 0; m_lim = 16; m_cnt = 0;
        for (int i = 0; i < 3000; i++) begin
            logic        nw, no, nwe;
            logic [1:0]  na;
            logic [15:0] nd;
            rd(2'd1, r);
            chk("R6", "rand nmi", nmi, m_nmi_f(m_stat, m_ctrl));
            chk("R8", "rand hold", hold, m_hold);
            chk("R4", "rand status", r, {13'd0, m_stat});
            if ($urandom_range(15) == 0) vmon = ~vmon;
            nw  = ($urandom_range(19) == 0);
            no  = ($urandom_range(19) == 0);
            nwe = ($urandom_range(5) == 0);
            na  = 2'($urandom_range(2));
            nd  = (na == 2'd2) ? 16'($urandom_range(6)) : 16'($urandom_range(31));
            wdg = nw; osc = no; bwr = nwe; baddr = na; bwdata = nd;
            model_step(vmon, nw, no, nwe, na, nd);
            @(posedge clk); @(negedge clk);
            bwr = 1'b0; wdg = 1'b0; osc = 1'b0;
        end
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end
endmodule